// File: doc/BRIEF.md
# Completion Timeout Counter with Multiplier

This block is a programmable watchdog for a host controller that waits for a device to assert its completion signal. A wait starts in one of two ways. For a command that carries data, it starts when the data transfer has fully ended, including any busy phase. For a command with no data phase, it starts at the end of the response. From the start event the block counts system clock cycles. If the completion signal has not arrived when the programmed limit is exceeded, the block raises a sticky timeout error flag.

The limit is set by a small configuration register with two fields: a cycle count and a multiplier selector. The selector picks a power-of-two scale from a fixed, nonlinear table. The limit is formed by shifting the count, not by multiplying it. While the write-protection input is high, writes to the register are dropped. The error flag stays set until an explicit clear strobe arrives.

Top module: `cmpl_timeout`

## Requirements
- R1: After reset the register reads as zero and `timeout_err` is low.
- R2: A write stores `cfg_wr_data[3:0]` as the cycle count and `cfg_wr_data[6:4]` as the multiplier selector. `cfg_rd_data` returns the count in bits 3:0 and the selector in bits 6:4. Bits 31:7 always read as zero.
- R3: A write made while `wprot_en` is high leaves the register unchanged.
- R4: The limit L is the cycle count times a multiplier. Selector values 0 to 7 give multipliers 1, 16, 128, 256, 1024, 4096, 65536 and 1048576.
- R5: A `data_end` pulse starts a wait. Call the clock edge that samples the pulse edge 0. If `cmpl_sig` is never sampled high, `timeout_err` is still low after edge L and goes high after edge L+1.
- R6: A `resp_end` pulse with `resp_no_data` high starts a wait in the same way. A `resp_end` pulse with `resp_no_data` low starts nothing.
- R7: If `cmpl_sig` is sampled high at any edge from 1 to L+1 of a wait, the wait ends with no error. This includes edge L+1 itself.
- R8: A start event during a wait restarts the count from zero, and the timing of R5 then runs from the new event.
- R9: `timeout_err` stays high, and start events are ignored, until `err_clr` is pulsed. After the clear the flag is low, and it stays low until a new start event is followed by a full timeout.
- R10: With a cycle count of zero the limit is zero, so the error rises after the first edge that follows the start event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_data | output | 32 | Register read data |
| wprot_en | input | 1 | Write protection; when high, writes are dropped |
| data_end | input | 1 | Pulse: data transfer and busy phase finished |
| resp_end | input | 1 | Pulse: command response finished |
| resp_no_data | input | 1 | The command of this response has no data phase |
| cmpl_sig | input | 1 | Completion signal from the device |
| err_clr | input | 1 | Pulse that clears the timeout error flag |
| timeout_err | output | 1 | Sticky timeout error flag |

## Verification
The assertions check four behaviours on every cycle:
- the upper read bits stay zero;
- a protected write leaves the register stable;
- a set error holds until it is cleared;
- a sampled completion, or a clear, always leaves the flag low on the next cycle.

Some behaviours can only be shown by the bench's scenarios. These are the exact edge on which the error rises for each multiplier, the last-edge race between completion and limit, a restart in the middle of a wait, and the start that is rejected because no-data is low.

// File: rtl/cmpl_timeout_pkg.sv
// Package: shared widths and the multiplier-selector decode for the
// completion timeout counter. Assumes the multipliers are powers of two.
package cmpl_timeout_pkg;
    localparam int CYC_W = 4;
    localparam int SEL_W = 3;
    localparam int LIM_W = 24;
    localparam int REG_W = 32;
    localparam int FLD_W = CYC_W + SEL_W;

    // Left-shift amount that stands for each multiplier selector value.
    function automatic int unsigned sel_to_shift(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 0;
            3'd1:    return 4;
            3'd2:    return 7;
            3'd3:    return 8;
            3'd4:    return 10;
            3'd5:    return 12;
            3'd6:    return 16;
            default: return 20;
        endcase
    endfunction
endpackage

// File: rtl/cto_cfg_reg.sv
// Configuration register: holds the cycle count and the multiplier selector.
// Assumes writes are single-cycle strobes. While prot is high, writes are dropped.
module cto_cfg_reg
    import cmpl_timeout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             prot,
    input  logic [FLD_W-1:0] wr_fld,
    output logic [CYC_W-1:0] cyc,
    output logic [SEL_W-1:0] sel
);
    // Capture both fields on an unprotected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
            sel <= '0;
        end else if (wr_en && !prot) begin
            cyc <= wr_fld[CYC_W-1:0];
            sel <= wr_fld[FLD_W-1:CYC_W];
        end
    end
endmodule

// File: rtl/cto_limit.sv
// Limit builder: scales the cycle count by the selected power of two.
// Uses a shift, not a multiplier. Assumes LIM_W holds 15 << 20.
module cto_limit
    import cmpl_timeout_pkg::*;
(
    input  logic [CYC_W-1:0] cyc,
    input  logic [SEL_W-1:0] sel,
    output logic [LIM_W-1:0] limit
);
    // Widen the count, then shift it by the decoded amount.
    always_comb begin
        limit = LIM_W'(cyc) << sel_to_shift(sel);
    end
endmodule

// File: rtl/cto_wait_ctr.sv
// Wait counter: counts cycles from a start event and flags an error once
// the count passes the limit. Completion ends the wait. The error is sticky
// and freezes the counter until clr. Assumes start, cmpl and clr are synchronous.
module cto_wait_ctr
    import cmpl_timeout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmpl,
    input  logic             clr,
    input  logic [LIM_W-1:0] limit,
    output logic             err
);
    logic             active;
    logic [LIM_W-1:0] cnt;

    // Sequence the wait: clear, then freeze, then restart, then complete or count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            err    <= 1'b0;
        end else if (clr) begin
            active <= 1'b0;
            cnt    <= '0;
            err    <= 1'b0;
        end else if (err) begin
            active <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cmpl) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (cnt >= limit) begin
                err    <= 1'b1;
                active <= 1'b0;
            end else begin
                cnt    <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmpl_timeout.sv
// Top: completion timeout counter. It joins the configuration register, the
// limit builder and the wait counter. Assumes the event inputs are
// one-cycle pulses, synchronous to clk.
module cmpl_timeout
    import cmpl_timeout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wr_data,
    output logic [REG_W-1:0] cfg_rd_data,
    input  logic             wprot_en,
    input  logic             data_end,
    input  logic             resp_end,
    input  logic             resp_no_data,
    input  logic             cmpl_sig,
    input  logic             err_clr,
    output logic             timeout_err
);
    logic [CYC_W-1:0] cyc;
    logic [SEL_W-1:0] sel;
    logic [LIM_W-1:0] limit;
    logic             start_evt;
    logic             unused_hi;

    assign unused_hi = ^cfg_wr_data[REG_W-1:FLD_W];

    // A wait begins at the end of data, or at the end of a data-less response.
    always_comb begin
        start_evt = data_end || (resp_end && resp_no_data);
    end

    // Read-back: fields in the low bits, zeros above them.
    always_comb begin
        cfg_rd_data = {{(REG_W-FLD_W){1'b0}}, sel, cyc};
    end

    cto_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .prot   (wprot_en),
        .wr_fld (cfg_wr_data[FLD_W-1:0]),
        .cyc    (cyc),
        .sel    (sel)
    );

    cto_limit u_lim (
        .cyc   (cyc),
        .sel   (sel),
        .limit (limit)
    );

    cto_wait_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_evt),
        .cmpl  (cmpl_sig),
        .clr   (err_clr),
        .limit (limit),
        .err   (timeout_err)
    );
endmodule

// File: rtl/cmpl_timeout_chk.sv
// Checker: port-level properties of the completion timeout counter.
// It is bound into every instance of the top module.
module cmpl_timeout_chk
    import cmpl_timeout_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [REG_W-1:0] cfg_rd_data,
    input logic             wprot_en,
    input logic             cmpl_sig,
    input logic             err_clr,
    input logic             timeout_err
);
    // R2: the bits above the fields always read as zero.
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[REG_W-1:FLD_W] == '0);

    // R3: a protected write leaves the register as it was.
    p_wprot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && wprot_en) |=> $stable(cfg_rd_data));

    // R7: a sampled completion never leads to an error on the next cycle.
    p_cmpl_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_sig && !timeout_err) |=> !timeout_err);

    // R9: the error holds until a clear arrives.
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && !err_clr) |=> timeout_err);

    // R9: a clear always drops the flag.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !timeout_err);
endmodule

bind cmpl_timeout cmpl_timeout_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_rd_data (cfg_rd_data),
    .wprot_en    (wprot_en),
    .cmpl_sig    (cmpl_sig),
    .err_clr     (err_clr),
    .timeout_err (timeout_err)
);

// File: tb/cmpl_timeout_bench.sv
// Bench: directed corner cases plus seeded random waits, checked against
// limits that are computed from the requirement table.
module cmpl_timeout_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        wprot_en = 1'b0;
    logic        data_end = 1'b0;
    logic        resp_end = 1'b0;
    logic        resp_no_data = 1'b0;
    logic        cmpl_sig = 1'b0;
    logic        err_clr = 1'b0;
    logic        timeout_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    cmpl_timeout u_cmpl_timeout (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .wprot_en(wprot_en), .data_end(data_end),
        .resp_end(resp_end), .resp_no_data(resp_no_data), .cmpl_sig(cmpl_sig),
        .err_clr(err_clr), .timeout_err(timeout_err)
    );

    function automatic longint exp_limit(input int cyc, input int sel);
        longint m;
        case (sel)
            0: m = 1;       1: m = 16;    2: m = 128;   3: m = 256;
            4: m = 1024;    5: m = 4096;  6: m = 65536; default: m = 1048576;
        endcase
        return cyc * m;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] d, input logic prot);
        @(negedge clk);
        cfg_wr_data = d; cfg_wr_en = 1'b1; wprot_en = prot;
        @(negedge clk);
        cfg_wr_en = 1'b0; wprot_en = 1'b0;
    endtask

    // kind 0: data_end, 1: resp_end with no-data, 2: resp_end with data
    // Ends at the negedge that follows edge 0.
    task automatic pulse_start(input int kind);
        @(negedge clk);
        if (kind == 0) data_end = 1'b1;
        else begin resp_end = 1'b1; resp_no_data = (kind == 1); end
        @(negedge clk);
        data_end = 1'b0; resp_end = 1'b0; resp_no_data = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    // Full timeout: low after edge L, high after edge L+1.
    task automatic timeout_run(input string req, input int kind, input longint lim);
        pulse_start(kind);
        repeat (lim) @(negedge clk);
        check(req, timeout_err, 0);
        @(negedge clk);
        check(req, timeout_err, 1);
        clear_err();
    endtask

    // Completion is driven j negedges after edge 0 and is sampled at edge j+1.
    task automatic cmpl_run(input string req, input longint lim, input longint j);
        pulse_start(0);
        repeat (j) @(negedge clk);
        cmpl_sig = 1'b1;
        @(negedge clk);
        cmpl_sig = 1'b0;
        repeat (lim - j + 3) @(negedge clk);
        check(req, timeout_err, 0);
    endtask

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h5eed_1234;
        int r = $urandom(seed);
        r = r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cfg", cfg_rd_data, 0);
        check("R1 err", timeout_err, 0);

        write_cfg(32'hFFFF_FF35, 1'b0);
        check("R2 readback", cfg_rd_data, 32'h35);
        write_cfg(32'h0000_0062, 1'b1);
        check("R3 protected", cfg_rd_data, 32'h35);

        // R10: count zero, so the limit is zero
        write_cfg(32'h0000_0000, 1'b0);
        timeout_run("R10", 0, 0);

        // R4 / R5: each reachable selector
        for (int s = 0; s <= 5; s++) begin
            int c = (s < 4) ? 3 : 1;
            write_cfg(32'(s * 16 + c), 1'b0);
            timeout_run("R4 R5", 0, exp_limit(c, s));
        end
        write_cfg(32'h0000_0061, 1'b0);
        timeout_run("R4 sel6", 1, exp_limit(1, 6));

        // R6: start with and without the no-data flag
        write_cfg(32'h0000_0005, 1'b0);
        timeout_run("R6 nodata", 1, 5);
        pulse_start(2);
        repeat (12) @(negedge clk);
        check("R6 with data", timeout_err, 0);

        // R7: completion on the first and on the last possible edge
        cmpl_run("R7 first", 5, 0);
        cmpl_run("R7 last", 5, 5);

        // R8: restart in the middle of a wait
        pulse_start(0);
        repeat (3) @(negedge clk);
        timeout_run("R8 restart", 0, 5);

        // R9: sticky; starts ignored; clear; no error without a start
        pulse_start(0);
        repeat (10) @(negedge clk);
        check("R9 set", timeout_err, 1);
        pulse_start(0);
        repeat (10) @(negedge clk);
        check("R9 sticky", timeout_err, 1);
        clear_err();
        check("R9 cleared", timeout_err, 0);
        repeat (10) @(negedge clk);
        check("R9 stays low", timeout_err, 0);

        // Random waits, with or without a completion
        for (int t = 0; t < 30; t++) begin
            int s = $urandom_range(0, 2);
            int c = $urandom_range(0, 15);
            longint lim = exp_limit(c, s);
            write_cfg(32'(s * 16 + c), 1'b0);
            check("R2 random", cfg_rd_data, s * 16 + c);
            if ($urandom_range(0, 1) == 1)
                cmpl_run("R7 random", lim, $urandom_range(0, int'(lim)));
            else
                timeout_run("R5 random", $urandom_range(0, 1), lim);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule